// File: doc/BRIEF.md
# Segmented Stream Fill-Rule Monitor

This block watches a segmented streaming bus on which each beat carries up to twelve 128-bit segments. Each segment has its own enable, start-of-packet and end-of-packet flags, and one valid signal covers the whole beat. The monitor does not carry the payload. It checks each valid beat against the rules on how segments may be filled. It records every kind of violation in a sticky flag, together with the segment that first broke that rule. It also emits a one-cycle pulse the first time each kind of violation appears.

Segments fill from segment 0 upward. A valid beat with segment 0 disabled is a full idle beat. A beat may end early with trailing disabled segments, but it may not reopen after a hole. The monitor reports a reopen separately depending on whether the segment just before the hole closed a packet.

A beat may carry at most three packet starts. Segments are grouped in fours, and each group has one preamble input. The monitor reports, for each group, the segment of the packet start that uses that group's preamble, and passes the matching preamble through. A second start in the same group is a violation, because the group has only one preamble.

Top module: `segstream_checker`

## Requirements
- R1: In a beat with valid high, segment 0 disabled and any other enable set, rule bit 0 (lead) is violated. Its index is the lowest enabled segment.
- R2: Let h be the first disabled segment above segment 0 in a beat with valid high and segment 0 enabled. If segment h-1 has no eop and any segment above h is enabled, rule bit 1 (gap) is violated. Its index is the lowest enabled segment above h.
- R3: Under the same conditions as R2 but with eop set on segment h-1, rule bit 2 (post-eop reopen) is violated instead, with the same index. Contiguous fill from segment 0 with trailing disabled segments is never a violation.
- R4: If more than three enabled segments carry sop in one valid beat, rule bit 3 (too many starts) is violated. Its index is the segment of the fourth such sop.
- R5: If two enabled segments with sop fall in the same group g (segments 4g to 4g+3), rule bit 4 (shared preamble) is violated. Its index is the second sop segment of the lowest such group.
- R6: When valid is low, enable, sop and eop are ignored: no rule is checked and the preamble outputs show no start. Flags on disabled segments are ignored, and a valid beat with every enable clear is legal.
- R7: Each rule flag is sticky. The index of a rule is captured in the beat that first sets its flag and is held while the flag stays set, whatever later beats do.
- R8: A rule's pulse bit is high for exactly the one cycle in which its flag goes from 0 to 1.
- R9: The synchronous clear input zeroes all flags, indexes and pulses on the next edge. It takes priority over a violation in the same beat, and that violation is dropped.
- R10: For each group g, one cycle after a valid beat, pre_vld[g] is 1 when an enabled segment of the group has sop. pre_seg (4 bits per group, group g at bits 4g+3:4g) then holds the lowest such segment number, and pre_data (56 bits per group) holds preamble input g. With no start in the group, all three are 0.
- R11: While reset is asserted, all outputs are 0. Every output is registered, so a beat sampled at a clock edge is reflected at the outputs just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of flags and indexes |
| valid | input | 1 | Beat valid |
| ena | input | 12 | Per-segment enable |
| sop | input | 12 | Per-segment start of packet |
| eop | input | 12 | Per-segment end of packet |
| pre_in | input | 168 | Preamble inputs, group g at bits 56g+55:56g |
| viol_flag | output | 5 | Sticky flag per rule (bit order lead, gap, post-eop, starts, shared preamble) |
| viol_pulse | output | 5 | First-occurrence pulse per rule |
| viol_idx | output | 20 | Captured segment index per rule, rule r at bits 4r+3:4r |
| pre_vld | output | 3 | Group has a packet start this beat |
| pre_seg | output | 12 | Segment of the start using each group's preamble |
| pre_data | output | 168 | Preamble selected for each group |

## Verification
The hardest case to reach is a violation that arrives while its flag is already set, or in the same beat as a clear. Nothing changes at the ports then, so a wrong overwrite of the captured index shows only by its absence. The stimulus sets each rule with a known index, then repeats the violation at a different segment, and finally pulses clear together with a fresh violation. Random beats biased toward contiguous fills, with occasional holes placed after eop and non-eop segments, keep the post-eop and gap rules apart.

// File: rtl/segstream_pkg.sv
package segstream_pkg;
    localparam int NUM_RULES = 5;

    typedef enum logic [2:0] {
        RULE_LEAD    = 3'd0,
        RULE_GAP     = 3'd1,
        RULE_POSTEOP = 3'd2,
        RULE_SOPMAX  = 3'd3,
        RULE_GRPDUP  = 3'd4
    } rule_e;
endpackage

// File: rtl/segstream_fill_check.sv
module segstream_fill_check #(
    parameter int NUM_SEG = 12,
    parameter int MAX_SOP = 3,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [NUM_SEG-1:0] ena,
    input  logic [NUM_SEG-1:0] sop,
    input  logic [NUM_SEG-1:0] eop,
    output logic               lead_hit,
    output logic [IDX_W-1:0]   lead_idx,
    output logic               gap_hit,
    output logic [IDX_W-1:0]   gap_idx,
    output logic               post_hit,
    output logic [IDX_W-1:0]   post_idx,
    output logic               many_hit,
    output logic [IDX_W-1:0]   many_idx
);
    logic [NUM_SEG-1:0] act;
    logic               hole_found, eop_before, prev_eop, late_hit;
    int                 hole_at, sop_cnt;
    logic [IDX_W-1:0]   late_idx;

    always_comb begin
        act        = valid ? ena : '0;
        lead_hit   = 1'b0;
        lead_idx   = '0;
        hole_found = 1'b0;
        hole_at    = 0;
        eop_before = 1'b0;
        prev_eop   = 1'b0;
        late_hit   = 1'b0;
        late_idx   = '0;
        many_hit   = 1'b0;
        many_idx   = '0;
        sop_cnt    = 0;

        // lead rule: data present while segment 0 is off
        if (!act[0]) begin
            for (int i = NUM_SEG - 1; i >= 1; i--) begin
                if (act[i]) begin
                    lead_hit = 1'b1;
                    lead_idx = IDX_W'(i);
                end
            end
        end

        // first hole and the eop state of the segment just before it
        for (int i = 0; i < NUM_SEG; i++) begin
            if (i > 0 && act[0] && !act[i] && !hole_found) begin
                hole_found = 1'b1;
                hole_at    = i;
                eop_before = prev_eop;
            end
            prev_eop = eop[i];
        end

        // any segment active above the hole
        for (int i = NUM_SEG - 1; i >= 1; i--) begin
            if (hole_found && i > hole_at && act[i]) begin
                late_hit = 1'b1;
                late_idx = IDX_W'(i);
            end
        end

        // start count
        for (int i = 0; i < NUM_SEG; i++) begin
            if (act[i] && sop[i]) begin
                if (sop_cnt == MAX_SOP && !many_hit) begin
                    many_hit = 1'b1;
                    many_idx = IDX_W'(i);
                end
                sop_cnt++;
            end
        end
    end

    assign gap_hit  = late_hit && !eop_before;
    assign post_hit = late_hit && eop_before;
    assign gap_idx  = late_idx;
    assign post_idx = late_idx;

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !(lead_hit || gap_hit || post_hit || many_hit));
    a_r2_gap_idx_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        gap_hit |-> ena[gap_idx] && ena[0]);
    a_r1_lead_seg0_off: assert property (@(posedge clk) disable iff (!rst_n)
        lead_hit |-> !ena[0] && ena[lead_idx]);
endmodule

// File: rtl/segstream_pre_pick.sv
module segstream_pre_pick #(
    parameter int GRP_SEGS = 4,
    parameter int IDX_W    = 4,
    parameter int GRP_BASE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic [GRP_SEGS-1:0] ena,
    input  logic [GRP_SEGS-1:0] sop,
    output logic                hit,
    output logic [IDX_W-1:0]    first_idx,
    output logic                dup,
    output logic [IDX_W-1:0]    second_idx
);
    int first_off, second_off;

    always_comb begin
        hit        = 1'b0;
        dup        = 1'b0;
        first_off  = 0;
        second_off = 0;
        for (int i = 0; i < GRP_SEGS; i++) begin
            if (valid && ena[i] && sop[i]) begin
                if (hit && !dup) begin
                    dup        = 1'b1;
                    second_off = i;
                end
                if (!hit) begin
                    hit       = 1'b1;
                    first_off = i;
                end
            end
        end
    end

    assign first_idx  = IDX_W'(GRP_BASE + first_off);
    assign second_idx = IDX_W'(GRP_BASE + second_off);

    a_r10_start_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (int'(first_idx) >= GRP_BASE) && (int'(first_idx) < GRP_BASE + GRP_SEGS));
    a_r5_dup_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        dup |-> hit && (second_idx > first_idx));
endmodule

// File: rtl/segstream_checker.sv
module segstream_checker
    import segstream_pkg::*;
#(
    parameter int NUM_SEG  = 12,
    parameter int GRP_SEGS = 4,
    parameter int MAX_SOP  = 3,
    parameter int PRE_W    = 56,
    localparam int NUM_GRP = NUM_SEG / GRP_SEGS,
    localparam int IDX_W   = $clog2(NUM_SEG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       valid,
    input  logic [NUM_SEG-1:0]         ena,
    input  logic [NUM_SEG-1:0]         sop,
    input  logic [NUM_SEG-1:0]         eop,
    input  logic [NUM_GRP*PRE_W-1:0]   pre_in,
    output logic [NUM_RULES-1:0]       viol_flag,
    output logic [NUM_RULES-1:0]       viol_pulse,
    output logic [NUM_RULES*IDX_W-1:0] viol_idx,
    output logic [NUM_GRP-1:0]         pre_vld,
    output logic [NUM_GRP*IDX_W-1:0]   pre_seg,
    output logic [NUM_GRP*PRE_W-1:0]   pre_data
);
    typedef struct packed {
        logic [NUM_RULES-1:0]            flag;
        logic [NUM_RULES-1:0]            pulse;
        logic [NUM_RULES-1:0][IDX_W-1:0] idx;
        logic [NUM_GRP-1:0]              pvld;
        logic [NUM_GRP-1:0][IDX_W-1:0]   pseg;
        logic [NUM_GRP-1:0][PRE_W-1:0]   pdat;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_RULES-1:0]            hit;
    logic [NUM_RULES-1:0][IDX_W-1:0] cand;
    logic [NUM_GRP-1:0]              grp_hit, grp_dup;
    logic [NUM_GRP-1:0][IDX_W-1:0]   grp_first, grp_second;

    segstream_fill_check #(
        .NUM_SEG (NUM_SEG),
        .MAX_SOP (MAX_SOP),
        .IDX_W   (IDX_W)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (valid),
        .ena      (ena),
        .sop      (sop),
        .eop      (eop),
        .lead_hit (hit[RULE_LEAD]),
        .lead_idx (cand[RULE_LEAD]),
        .gap_hit  (hit[RULE_GAP]),
        .gap_idx  (cand[RULE_GAP]),
        .post_hit (hit[RULE_POSTEOP]),
        .post_idx (cand[RULE_POSTEOP]),
        .many_hit (hit[RULE_SOPMAX]),
        .many_idx (cand[RULE_SOPMAX])
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        segstream_pre_pick #(
            .GRP_SEGS (GRP_SEGS),
            .IDX_W    (IDX_W),
            .GRP_BASE (g * GRP_SEGS)
        ) u_pick (
            .clk        (clk),
            .rst_n      (rst_n),
            .valid      (valid),
            .ena        (ena[g*GRP_SEGS +: GRP_SEGS]),
            .sop        (sop[g*GRP_SEGS +: GRP_SEGS]),
            .hit        (grp_hit[g]),
            .first_idx  (grp_first[g]),
            .dup        (grp_dup[g]),
            .second_idx (grp_second[g])
        );
    end

    // lowest group holding two starts decides the shared-preamble index
    always_comb begin
        hit[RULE_GRPDUP]  = 1'b0;
        cand[RULE_GRPDUP] = '0;
        for (int g = NUM_GRP - 1; g >= 0; g--) begin
            if (grp_dup[g]) begin
                hit[RULE_GRPDUP]  = 1'b1;
                cand[RULE_GRPDUP] = grp_second[g];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.flag  = '0;
            st_d.pulse = '0;
            st_d.idx   = '0;
        end else begin
            for (int r = 0; r < NUM_RULES; r++) begin
                st_d.pulse[r] = hit[r] && !st_q.flag[r];
                if (hit[r] && !st_q.flag[r]) begin
                    st_d.flag[r] = 1'b1;
                    st_d.idx[r]  = cand[r];
                end
            end
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            st_d.pvld[g] = grp_hit[g];
            st_d.pseg[g] = grp_hit[g] ? grp_first[g] : '0;
            st_d.pdat[g] = grp_hit[g] ? pre_in[g*PRE_W +: PRE_W] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign viol_flag  = st_q.flag;
    assign viol_pulse = st_q.pulse;
    assign viol_idx   = st_q.idx;
    assign pre_vld    = st_q.pvld;
    assign pre_seg    = st_q.pseg;
    assign pre_data   = st_q.pdat;

    a_r9_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (viol_flag == '0) && (viol_pulse == '0) && (viol_idx == '0));

    for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule_chk
        a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            viol_pulse[r] |-> viol_flag[r] && !$past(viol_flag[r]));
        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            viol_flag[r] && !clear |=> viol_flag[r]);
        a_r7_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
            viol_flag[r] && !clear |=> $stable(viol_idx[r*IDX_W +: IDX_W]));
    end
endmodule

// File: tb/segstream_checker_tb.sv
module segstream_checker_tb;
    localparam int NS = 12;
    localparam int NG = 3;
    localparam int NR = 5;
    localparam int PW = 56;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clear = 1'b0;
    logic             valid = 1'b0;
    logic [NS-1:0]    ena = '0, sop = '0, eop = '0;
    logic [NG*PW-1:0] pre_in = '0;
    logic [NR-1:0]    viol_flag, viol_pulse;
    logic [NR*4-1:0]  viol_idx;
    logic [NG-1:0]    pre_vld;
    logic [NG*4-1:0]  pre_seg;
    logic [NG*PW-1:0] pre_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    bit          m_flag[NR];
    bit          m_pulse[NR];
    int          m_idx[NR];
    bit          m_pvld[NG];
    int          m_pseg[NG];
    logic [PW-1:0] m_pdat[NG];
    string       rtag[NR] = '{"R1", "R2", "R3", "R4", "R5"};

    always #2 clk = ~clk;

    segstream_checker u_dut (
        .clk (clk), .rst_n (rst_n), .clear (clear), .valid (valid),
        .ena (ena), .sop (sop), .eop (eop), .pre_in (pre_in),
        .viol_flag (viol_flag), .viol_pulse (viol_pulse), .viol_idx (viol_idx),
        .pre_vld (pre_vld), .pre_seg (pre_seg), .pre_data (pre_data)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < NR; r++) begin
            m_flag[r] = 0; m_pulse[r] = 0; m_idx[r] = 0;
        end
        for (int g = 0; g < NG; g++) begin
            m_pvld[g] = 0; m_pseg[g] = 0; m_pdat[g] = '0;
        end
    endtask

    task automatic model_step();
        bit hit[NR];
        int cand[NR];
        int sq[$];
        int k;
        for (int r = 0; r < NR; r++) begin hit[r] = 0; cand[r] = 0; end
        for (int g = 0; g < NG; g++) begin m_pvld[g] = 0; m_pseg[g] = 0; m_pdat[g] = '0; end
        if (valid) begin
            if (!ena[0] && ena != 0) begin
                hit[0] = 1;
                for (int i = NS - 1; i >= 0; i--) if (ena[i]) cand[0] = i;
            end
            if (ena[0]) begin
                k = 0;
                while (k < NS && ena[k]) k++;
                for (int i = NS - 1; i > k; i--) begin
                    if (ena[i]) begin
                        if (eop[k-1]) begin hit[2] = 1; cand[2] = i; end
                        else          begin hit[1] = 1; cand[1] = i; end
                    end
                end
            end
            for (int i = 0; i < NS; i++) if (ena[i] && sop[i]) sq.push_back(i);
            if (sq.size() > 3) begin hit[3] = 1; cand[3] = sq[3]; end
            for (int g = 0; g < NG; g++) begin
                int gq[$];
                for (int i = 4 * g; i < 4 * g + 4; i++) if (ena[i] && sop[i]) gq.push_back(i);
                if (gq.size() >= 2 && !hit[4]) begin hit[4] = 1; cand[4] = gq[1]; end
                if (gq.size() > 0) begin
                    m_pvld[g] = 1; m_pseg[g] = gq[0]; m_pdat[g] = pre_in[g*PW +: PW];
                end
            end
        end
        for (int r = 0; r < NR; r++) begin
            if (clear) begin
                m_flag[r] = 0; m_pulse[r] = 0; m_idx[r] = 0;
            end else begin
                m_pulse[r] = hit[r] && !m_flag[r];
                if (hit[r] && !m_flag[r]) begin m_flag[r] = 1; m_idx[r] = cand[r]; end
            end
        end
    endtask

    task automatic compare(string note);
        for (int r = 0; r < NR; r++) begin
            chk(rtag[r], {note, " idx"}, 64'(viol_idx[r*4 +: 4]), 64'(m_idx[r]));
            chk("R7", {note, " flag ", rtag[r]}, 64'(viol_flag[r]), 64'(m_flag[r]));
            chk("R8", {note, " pulse ", rtag[r]}, 64'(viol_pulse[r]), 64'(m_pulse[r]));
        end
        for (int g = 0; g < NG; g++) begin
            chk("R10", {note, " pre_vld"}, 64'(pre_vld[g]), 64'(m_pvld[g]));
            chk("R10", {note, " pre_seg"}, 64'(pre_seg[g*4 +: 4]), 64'(m_pseg[g]));
            chk("R10", {note, " pre_data"}, 64'(pre_data[g*PW +: PW]), 64'(m_pdat[g]));
        end
    endtask

    // drive at the falling edge, model at the rising edge, compare at the next falling edge
    task automatic beat(string note, bit v, logic [NS-1:0] e, logic [NS-1:0] s,
                        logic [NS-1:0] eo, bit clr);
        valid = v; ena = e; sop = s; eop = eo; clear = clr;
        for (int g = 0; g < NG; g++) pre_in[g*PW +: PW] = {$urandom(), $urandom()} & {PW{1'b1}};
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(note);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare("R11 reset");
        chk("R11", "reset flags", 64'(viol_flag), 64'(0));
        rst_n = 1'b1;

        // R6: enables with valid low are ignored; all-off valid beat is idle
        beat("R6 valid low", 0, 12'hF0F, 12'h111, 12'h000, 0);
        beat("R6 idle", 1, 12'h000, 12'h0FF, 12'hFFF, 0);
        beat("R6 flags on off segs", 1, 12'h003, 12'hFF0, 12'hFF0, 0);
        // legal fills: trailing inactive with and without eop (R3)
        beat("R3 legal trail eop", 1, 12'h01F, 12'h001, 12'h010, 0);
        beat("R3 legal trail", 1, 12'h007, 12'h000, 12'h000, 0);
        beat("R3 full", 1, 12'hFFF, 12'h111, 12'h888, 0);
        // R1: segment 0 off with data at 3
        beat("R1 lead", 1, 12'h0F8, 12'h000, 12'h000, 0);
        // R7: second lead violation at another index keeps first index
        beat("R7 lead again", 1, 12'h020, 12'h000, 12'h000, 0);
        // R2: hole at 2 after non-eop segment 1, reopen at 5
        beat("R2 gap", 1, 12'h063, 12'h000, 12'h000, 0);
        // R3: hole at 4 after eop on 3, reopen at 9
        beat("R3 post eop", 1, 12'h20F, 12'h001, 12'h008, 0);
        // R5: two starts in group 1 (segments 4 and 6)
        beat("R5 group dup", 1, 12'h0FF, 12'h051, 12'h020, 0);
        // R4: four starts, one per group would allow three; fourth at 9
        beat("R4 many", 1, 12'hFFF, 12'h311, 12'h000, 0);
        // R9: clear with a simultaneous violation drops it
        beat("R9 clear", 1, 12'h0F0, 12'h000, 12'h000, 1);
        chk("R9", "flags after clear", 64'(viol_flag), 64'(0));
        beat("R9 after clear", 1, 12'h0F0, 12'h000, 12'h000, 0);
        beat("R9 clear only", 0, 12'h000, 12'h000, 12'h000, 1);
        // R10: one start per group
        beat("R10 starts", 1, 12'hFFF, 12'h824, 12'h412, 0);

        for (int n = 0; n < 3000; n++) begin
            logic [NS-1:0] e, s, eo;
            int fill = $urandom_range(0, NS);
            e = (fill == NS) ? '1 : NS'((1 << fill) - 1);
            if ($urandom_range(0, 4) == 0) e = e | NS'(1 << $urandom_range(0, NS - 1));
            if ($urandom_range(0, 9) == 0) e = e & ~NS'(1);
            s = NS'($urandom()) & NS'($urandom()) & NS'($urandom());
            eo = NS'($urandom()) & NS'($urandom());
            beat("random", $urandom_range(0, 9) != 0, e, s, eo, $urandom_range(0, 39) == 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule